// File: doc/BRIEF.md
# Page Command Sequencer for Delta-Modulated Voice Storage

This block runs the store, play and wait commands of a voice recorder whose audio is held as a one-bit delta-modulated stream in external DRAM. It derives a bit-rate strobe from the reference clock. For each command it steps through a fixed number of bit periods, 1024 by default. A store command writes one encoder bit per period into consecutive addresses of the selected page. A play command reads the page back bit by bit onto the decoder output. A wait command touches no memory.

A one-entry command buffer sits in front of the executing command. The controller can load the next command while the current one runs, and the buffered command starts on the bit period right after the current one ends. Each new command replaces whatever the buffer holds. Two status bits show whether the buffer is empty and whether the sequencer is idle. After every store or wait run in encode mode, the block publishes a saturating 5-bit input power figure with a one-cycle update strobe.

Memory is reached through a simple request/acknowledge port. Command loads are single-cycle valid pulses that are always accepted. The analog modulator and demodulator are outside this block.

Top module: `vsr_page_sequencer`

## Requirements
- R1: `bit_stb` is a one-cycle pulse every DIV_FAST clocks (default 64) when `rate_hi` is 1, and every DIV_SLOW clocks (default 128) when it is 0.
- R2: A command run on its own keeps `st_idle` low for exactly BITS bit periods (default 1024).
- R3: The buffer holds one command. A load while it is full overwrites the entry, so only the most recently loaded command runs. `cmd_wait` = 1 loads a wait and `cmd_wait` = 0 loads a page command.
- R4: When the running command ends with the buffer full, the buffered command starts on the next bit period with no idle gap. `st_idle` rises only when the buffer is empty.
- R5: After reset `st_empty` = 1 and `st_idle` = 1. A load clears `st_empty` on the following cycle. `st_empty` returns to 1 when the entry is taken. `st_idle` is 0 exactly while a command is executing.
- R6: A page command started with `decode` = 0 stores. Bit i of the run is written to `mem_addr` = {page, i}, where page is the low PAGE_W bits of `cmd_arg`. The higher bits of `cmd_arg` are ignored.
- R7: A page command started with `decode` = 1 plays. `dec_bit` presents the page's stored bits in address order, one per bit period.
- R8: Whenever no play run is active (idle, any wait, any store), `dec_bit` alternates 1,0,1,0 on successive bit periods.
- R9: A store run while `powersave` = 1 writes the alternating idle pattern instead of `enc_bit`.
- R10: At the end of each store or wait run started with `decode` = 0, `pwr_val` takes the count of bit periods whose stored sample equals the previous sample, shifted right by PWR_SHIFT and saturated at 31, and `pwr_upd` pulses once. Play runs and decode-mode waits leave both unchanged.
- R11: A one-cycle `clr` aborts the running command, empties the buffer and drops any memory request on the next cycle, and nothing further is written.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | General reset pulse: abort and empty buffer |
| rate_hi | input | 1 | 1 selects the fast bit rate |
| decode | input | 1 | 1 plays, 0 stores (sampled at command start) |
| powersave | input | 1 | Encoder powered down: store the idle pattern |
| cmd_valid | input | 1 | Load a command into the buffer |
| cmd_wait | input | 1 | 1 = wait command, 0 = page command |
| cmd_arg | input | ARG_W | Page argument, low PAGE_W bits used |
| enc_bit | input | 1 | Encoder output bit |
| dec_bit | output | 1 | Bit stream to the decoder |
| bit_stb | output | 1 | Bit-period strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | PAGE_W+log2(BITS) | {page, bit index} |
| mem_wdata | output | 1 | Bit to write |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 1 | Bit read, valid with `mem_ack` |
| st_empty | output | 1 | Buffer empty status |
| st_idle | output | 1 | No command executing |
| pwr_val | output | PWR_W | Saturated input power figure |
| pwr_upd | output | 1 | One-cycle pulse when `pwr_val` is refreshed |

## Verification
The assertions check on every cycle that the strobe is a single-cycle pulse, that memory requests are held until acknowledged, that a load always fills the buffer, that a clear leaves the block idle and empty, that idle is never entered while a command waits in the buffer, and that power updates are isolated pulses. Only the bench's scenarios can show the content of the data path: which encoder bits land at which addresses, that play returns them in order, the alternating idle stream, the measured run lengths, which of two overwritten commands actually runs, and the power arithmetic including saturation.

// File: rtl/pgseq_pkg.sv
// Shared types for the page command sequencer.
package pgseq_pkg;
    // Operation latched when a buffered command begins executing.
    typedef enum logic [1:0] {
        OP_WAIT_ENC = 2'd0,
        OP_WAIT_DEC = 2'd1,
        OP_STORE    = 2'd2,
        OP_PLAY     = 2'd3
    } pg_op_e;
endpackage

// File: rtl/pgseq_bitclk.sv
// Bit-rate strobe generator.
// Divides the reference clock by DIV_FAST or DIV_SLOW, selected live by
// rate_hi. Assumes 2 <= DIV_FAST <= DIV_SLOW. stb is a registered single-cycle pulse.
module pgseq_bitclk #(
    parameter int DIV_FAST = 64,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_hi,
    output logic stb
);
    localparam int CW = $clog2(DIV_SLOW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the terminal count for the current rate.
    always_comb lim = rate_hi ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

    // Free-running divider that pulses stb once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            stb <= 1'b0;
        end else if (cnt >= lim) begin
            cnt <= '0;
            stb <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            stb <= 1'b0;
        end
    end

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R1
endmodule

// File: rtl/pgseq_cmdbuf.sv
// One-entry command buffer.
// A load always overwrites the entry. A take empties it unless a load lands
// in the same cycle. clr empties it. The caller takes only when full is set.
module pgseq_cmdbuf #(
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              load_wait,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              take,
    output logic              full,
    output logic              ent_wait,
    output logic [PAGE_W-1:0] ent_page
);
    // Hold the latest command until the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full     <= 1'b0;
            ent_wait <= 1'b0;
            ent_page <= '0;
        end else if (load) begin
            full     <= 1'b1;
            ent_wait <= load_wait;
            ent_page <= load_page;
        end else if (take) begin
            full     <= 1'b0;
        end
    end

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load && !clr |=> full); // R5
endmodule

// File: rtl/pgseq_pwr.sv
// Input power meter.
// Counts the bit periods in a run whose sample equals the previous sample
// (long runs mean slope overload, i.e. a loud input). At the run's end it
// publishes the count shifted right by SHIFT, saturated to PWR_W bits.
// The previous sample carries across runs.
module pgseq_pwr #(
    parameter int CNT_W = 11,
    parameter int SHIFT = 5,
    parameter int PWR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             first,
    input  logic             finish,
    input  logic             sample,
    output logic [PWR_W-1:0] pwr,
    output logic             upd
);
    localparam int WW   = CNT_W + PWR_W;
    localparam int PMAX = (1 << PWR_W) - 1;

    logic             prev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [WW-1:0]    wide;
    logic [PWR_W-1:0] sat;

    // Next count and its scaled, saturated value.
    always_comb begin
        cnt_nx = (first ? '0 : cnt) + CNT_W'(sample == prev);
        wide   = WW'(cnt_nx >> SHIFT);
        sat    = (wide > WW'(PMAX)) ? PWR_W'(PMAX) : wide[PWR_W-1:0];
    end

    // Accumulate per sample and publish at the end of a measured run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
            pwr  <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (sample_en) begin
                prev <= sample;
                cnt  <= cnt_nx;
                if (finish) begin
                    pwr <= sat;
                    upd <= 1'b1;
                end
            end
        end
    end

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd); // R10
endmodule

// File: rtl/vsr_page_sequencer.sv
// Page command sequencer: runs store/play/wait commands of BITS bit periods,
// with a one-entry buffer so consecutive commands run back to back.
// Assumes each memory access is acknowledged before the next bit strobe,
// and ARG_W > PAGE_W. decode and powersave are sampled as used.
module vsr_page_sequencer
    import pgseq_pkg::*;
#(
    parameter int PAGE_W    = 12,
    parameter int BITS      = 1024,
    parameter int DIV_FAST  = 64,
    parameter int DIV_SLOW  = 128,
    parameter int PWR_SHIFT = 5,
    parameter int PWR_W     = 5,
    parameter int ARG_W     = 16,
    localparam int IDX_W    = $clog2(BITS),
    localparam int ADDR_W   = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rate_hi,
    input  logic              decode,
    input  logic              powersave,
    input  logic              cmd_valid,
    input  logic              cmd_wait,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              enc_bit,
    output logic              dec_bit,
    output logic              bit_stb,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_rdata,
    output logic              st_empty,
    output logic              st_idle,
    output logic [PWR_W-1:0]  pwr_val,
    output logic              pwr_upd
);
    localparam int          CNT_W = IDX_W + 1;
    localparam [IDX_W-1:0]  LAST  = IDX_W'(BITS - 1);

    logic              buf_full, ent_wait, take;
    logic [PAGE_W-1:0] ent_page, cur_page;
    logic [IDX_W-1:0]  idx;
    logic              busy, idle_ph, sample, at_last, measure;
    pg_op_e            op, new_op;
    logic              unused_arg_hi;

    assign unused_arg_hi = ^cmd_arg[ARG_W-1:PAGE_W];

    pgseq_bitclk #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_clk (
        .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .stb(bit_stb)
    );

    pgseq_cmdbuf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .load(cmd_valid), .load_wait(cmd_wait), .load_page(cmd_arg[PAGE_W-1:0]),
        .take(take), .full(buf_full), .ent_wait(ent_wait), .ent_page(ent_page)
    );

    // Decode strobe-time conditions and the operation of the next command.
    always_comb begin
        at_last = busy && (idx == LAST);
        take    = bit_stb && buf_full && (!busy || at_last);
        sample  = powersave ? idle_ph : enc_bit;
        measure = busy && (op == OP_STORE || op == OP_WAIT_ENC);
        if (ent_wait) new_op = decode ? OP_WAIT_DEC : OP_WAIT_ENC;
        else          new_op = decode ? OP_PLAY     : OP_STORE;
    end

    // Command execution: take a buffered command, step the bit index, finish.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy     <= 1'b0;
            idx      <= '0;
            op       <= OP_WAIT_ENC;
            cur_page <= '0;
        end else if (bit_stb) begin
            if (take) begin
                busy     <= 1'b1;
                idx      <= '0;
                op       <= new_op;
                cur_page <= ent_page;
            end else if (at_last) begin
                busy     <= 1'b0;
            end else if (busy) begin
                idx      <= idx + 1'b1;
            end
        end
    end

    // Memory port: one access per bit period of a store or play run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= 1'b0;
        end else if (bit_stb && busy && (op == OP_STORE || op == OP_PLAY)) begin
            mem_req   <= 1'b1;
            mem_we    <= (op == OP_STORE);
            mem_addr  <= {cur_page, idx};
            mem_wdata <= sample;
        end else if (mem_req && mem_ack) begin
            mem_req   <= 1'b0;
        end
    end

    // Decoder stream: idle pattern unless a play run supplies read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_ph <= 1'b1;
            dec_bit <= 1'b0;
        end else begin
            if (bit_stb) idle_ph <= ~idle_ph;
            if (bit_stb && !(busy && op == OP_PLAY)) dec_bit <= idle_ph;
            else if (mem_req && mem_ack && !mem_we) dec_bit <= mem_rdata;
        end
    end

    pgseq_pwr #(.CNT_W(CNT_W), .SHIFT(PWR_SHIFT), .PWR_W(PWR_W)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .sample_en(bit_stb && measure && !clr), .first(idx == '0),
        .finish(at_last), .sample(sample),
        .pwr(pwr_val), .upd(pwr_upd)
    );

    assign st_empty = !buf_full;
    assign st_idle  = !busy;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !clr |=> mem_req && $stable(mem_addr)); // R12
    AST_CLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_idle && st_empty && !mem_req); // R11
    AST_NO_IDLE_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_idle) && !$past(cmd_valid) |-> st_empty); // R4
    AST_UPD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_upd |-> $past(bit_stb)); // R10
endmodule

// File: tb/tb_vsr_page_sequencer.sv
module tb_vsr_page_sequencer;
    localparam int PW = 4, NB = 64, DF = 4, DS = 8;
    localparam int NLAB = 8192;

    logic clk = 0, rst_n = 0, clr = 0, rate_hi = 1, decode = 0, powersave = 0;
    logic cmd_valid = 0, cmd_wait = 0, enc_bit = 0;
    logic [15:0] cmd_arg = '0;
    logic dec_bit, bit_stb, mem_req, mem_we, mem_wdata, st_empty, st_idle, pwr_upd;
    logic mem_ack, mem_rdata;
    logic [9:0] mem_addr;
    logic [4:0] pwr_val;

    always #2 clk = ~clk;

    vsr_page_sequencer #(.PAGE_W(PW), .BITS(NB), .DIV_FAST(DF), .DIV_SLOW(DS),
                         .PWR_SHIFT(0)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rate_hi(rate_hi), .decode(decode),
        .powersave(powersave), .cmd_valid(cmd_valid), .cmd_wait(cmd_wait),
        .cmd_arg(cmd_arg), .enc_bit(enc_bit), .dec_bit(dec_bit), .bit_stb(bit_stb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .st_empty(st_empty),
        .st_idle(st_idle), .pwr_val(pwr_val), .pwr_upd(pwr_upd));

    // Bench memory with a two-cycle acknowledge and per-page write counts.
    logic mem [0:1023];
    int   wr_cnt [0:15];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack   <= mem_req & ~mem_ack;
            mem_rdata <= mem[mem_addr];
            if (mem_req && !mem_ack && mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt[mem_addr[9:6]] <= wr_cnt[mem_addr[9:6]] + 1;
            end
        end
    end

    // Encoder stimulus and per-strobe observation, at the falling edge.
    int  lab = 0, pat_sel = 0, busy_clk = 0, upd_cnt = 0, last_pwr = 0;
    bit  idle_at [0:NLAB-1];
    bit  dec_at  [0:NLAB-1];

    function automatic logic gfun(int sel, int k);
        case (sel)
            0: return 1'b1;
            1: return k[0];
            default: return (k % 3) == 0;
        endcase
    endfunction

    function automatic int pwr_model(int start, logic prevbit, int sel);
        int c = 0;
        logic p = prevbit;
        for (int i = 0; i < NB; i++) begin
            logic s = gfun(sel, start + i);
            if (s == p) c++;
            p = s;
        end
        return (c > 31) ? 31 : c;
    endfunction

    always @(negedge clk) begin
        if (!st_idle) busy_clk++;
        if (pwr_upd) begin
            upd_cnt++;
            last_pwr = pwr_val;
        end
        if (bit_stb && lab < NLAB - 1) begin
            lab++;
            enc_bit     = gfun(pat_sel, lab);
            idle_at[lab] = st_idle;
            dec_at[lab]  = dec_bit;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic w, input logic [15:0] a);
        cmd_valid = 1; cmd_wait = w; cmd_arg = a;
        step();
        cmd_valid = 0;
    endtask

    task automatic wait_done();
        while (!(st_idle && st_empty)) step();
        repeat (40) step();
    endtask

    function automatic int find_start(int from);
        for (int j = from; j < NLAB; j++) if (!idle_at[j]) return j;
        return 0;
    endfunction

    task automatic measure_period(output int n);
        n = 0;
        while (!bit_stb) step();
        step();
        n = 1;
        while (!bit_stb) begin step(); n++; end
    endtask

    initial begin
        int n, s, L, b0, u0, bad;
        logic prevbit;
        for (int j = 0; j < NLAB; j++) idle_at[j] = 1;
        for (int j = 0; j < 1024; j++) mem[j] = 0;
        for (int j = 0; j < 16; j++) wr_cnt[j] = 0;
        repeat (5) step();
        rst_n = 1;
        step();

        // R5: reset state
        chk(st_empty == 1, "R5 reset empty", st_empty, 1);
        chk(st_idle == 1, "R5 reset idle", st_idle, 1);
        chk(mem_req == 0, "R12 reset no request", mem_req, 0);

        // R1: strobe period at both rates
        rate_hi = 1;
        measure_period(n); measure_period(n);
        chk(n == DF, "R1 fast period", n, DF);
        rate_hi = 0;
        measure_period(n); measure_period(n);
        chk(n == DS, "R1 slow period", n, DS);
        rate_hi = 1;
        measure_period(n);

        // R2 R8 R10: lone encode-mode wait, constant input saturates power
        pat_sel = 0; s = lab; b0 = busy_clk; u0 = upd_cnt;
        issue(1, 16'h0);
        wait_done();
        L = find_start(s);
        chk(busy_clk - b0 == NB * DF, "R2 wait length fast", busy_clk - b0, NB * DF);
        chk(upd_cnt == u0 + 1, "R10 update after wait", upd_cnt, u0 + 1);
        chk(last_pwr == pwr_model(L, 0, 0), "R10 saturated power", last_pwr, pwr_model(L, 0, 0));
        bad = 0;
        for (int j = L; j < L + NB - 1; j++) if (dec_at[j] == dec_at[j + 1]) bad++;
        chk(bad == 0, "R8 idle pattern during wait", bad, 0);
        prevbit = gfun(0, L + NB - 1);

        // R6 R10 R12: store page 3 with upper argument bits set
        pat_sel = 2; s = lab;
        issue(0, 16'hFFF3);
        wait_done();
        L = find_start(s);
        bad = 0;
        for (int i = 0; i < NB; i++) if (mem[3 * NB + i] != gfun(2, L + i)) bad++;
        chk(bad == 0, "R6 stored bits page 3", bad, 0);
        chk(wr_cnt[3] == NB, "R12 one write per bit", wr_cnt[3], NB);
        n = 0;
        for (int p = 0; p < 16; p++) if (p != 3) n += wr_cnt[p];
        chk(n == 0, "R6 upper argument bits ignored", n, 0);
        chk(last_pwr == pwr_model(L, prevbit, 2), "R10 unsaturated power", last_pwr,
            pwr_model(L, prevbit, 2));
        prevbit = gfun(2, L + NB - 1);

        // R7 R8 R10: play page 3
        decode = 1; s = lab; u0 = upd_cnt;
        issue(0, 16'h0003);
        wait_done();
        L = find_start(s);
        bad = 0;
        for (int i = 0; i < NB; i++) if (dec_at[L + i + 1] != mem[3 * NB + i]) bad++;
        chk(bad == 0, "R7 played bits page 3", bad, 0);
        chk(upd_cnt == u0, "R10 no update on play", upd_cnt, u0);
        chk(wr_cnt[3] == NB, "R7 play does not write", wr_cnt[3], NB);
        bad = 0;
        for (int j = L + NB + 2; j < L + NB + 6; j++) if (dec_at[j] == dec_at[j + 1]) bad++;
        chk(bad == 0, "R8 idle pattern after play", bad, 0);

        // R8 R10: decode-mode wait
        s = lab; u0 = upd_cnt;
        issue(1, 16'h0);
        wait_done();
        L = find_start(s);
        bad = 0;
        for (int j = L; j < L + NB - 1; j++) if (dec_at[j] == dec_at[j + 1]) bad++;
        chk(bad == 0, "R8 idle pattern decode wait", bad, 0);
        chk(upd_cnt == u0, "R10 no update on decode wait", upd_cnt, u0);

        // R3 R4 R5: back-to-back with an overwritten buffer entry
        decode = 0; pat_sel = 1; s = lab; b0 = busy_clk;
        issue(0, 16'h0005);
        while (st_idle) step();
        chk(st_empty == 1, "R5 empty after take", st_empty, 1);
        issue(0, 16'h0006);
        chk(st_empty == 0, "R5 load clears empty", st_empty, 0);
        issue(0, 16'h0007);
        while (!st_empty) step();
        chk(st_idle == 0, "R4 no idle between commands", st_idle, 0);
        wait_done();
        L = find_start(s);
        chk(busy_clk - b0 == 2 * NB * DF, "R4 gapless pair length", busy_clk - b0, 2 * NB * DF);
        chk(wr_cnt[6] == 0, "R3 overwritten command never runs", wr_cnt[6], 0);
        chk(wr_cnt[5] == NB, "R3 first command runs", wr_cnt[5], NB);
        chk(wr_cnt[7] == NB, "R3 latest command runs", wr_cnt[7], NB);
        bad = 0;
        for (int i = 0; i < NB; i++) if (mem[7 * NB + i] != gfun(1, L + NB + i)) bad++;
        chk(bad == 0, "R3 page 7 bits follow page 5 directly", bad, 0);
        chk(last_pwr == pwr_model(L + NB, gfun(1, L + NB - 1), 1), "R10 power after pair",
            last_pwr, pwr_model(L + NB, gfun(1, L + NB - 1), 1));

        // R2: wait at the slow rate
        rate_hi = 0; pat_sel = 0; b0 = busy_clk;
        issue(1, 16'h0);
        wait_done();
        chk(busy_clk - b0 == NB * DS, "R2 wait length slow", busy_clk - b0, NB * DS);
        rate_hi = 1;

        // R9: powersaved store writes alternating bits
        powersave = 1;
        issue(0, 16'h0009);
        wait_done();
        powersave = 0;
        bad = 0;
        for (int i = 0; i < NB - 1; i++) if (mem[9 * NB + i] == mem[9 * NB + i + 1]) bad++;
        chk(bad == 0, "R9 idle pattern stored", bad, 0);
        chk(wr_cnt[9] == NB, "R9 full page written", wr_cnt[9], NB);

        // R11: clear aborts a running store and drops the buffered one
        issue(0, 16'h000A);
        while (st_idle) step();
        repeat (40) step();
        issue(0, 16'h000B);
        clr = 1;
        step();
        clr = 0;
        chk(st_idle == 1, "R11 idle after clear", st_idle, 1);
        chk(st_empty == 1, "R11 empty after clear", st_empty, 1);
        chk(mem_req == 0, "R11 request dropped", mem_req, 0);
        n = wr_cnt[10];
        repeat (300) step();
        chk(wr_cnt[10] == n && n > 0 && n < NB, "R11 aborted page stops", wr_cnt[10], n);
        chk(wr_cnt[11] == 0, "R11 buffered command discarded", wr_cnt[11], 0);
        chk(st_idle == 1, "R11 stays idle", st_idle, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule